// File: doc/BRIEF.md
# Bus Master Replay Sequencer

This block is the transfer-issuing half of a master on a pipelined, address/data-overlapped system bus. After a start pulse it walks a run of word transfers from a base address: a NONSEQ beat first, then SEQ beats, each 4 bytes above the one before. The address phase of beat n+1 overlaps the data phase of beat n. Control and address outputs are registered. They move only on an edge where the slave reports ready, with one exception: a cancel.

Slaves may end a data phase with a two-cycle non-OKAY response. On the first of those two cycles, when ready is low, the sequencer reacts at once. For RETRY or SPLIT it withdraws the address it has already put out, drives IDLE for the second cycle, and rewinds to the failed beat, which goes out again later as a fresh NONSEQ. RETRY replays it as soon as the bus is held. SPLIT parks the master until the arbiter has taken the bus away and handed it back. For ERROR the failed beat is never repeated. A policy input chosen at start decides what happens next: either the rest of the run is dropped, with the pipelined address cancelled, or the remaining beats carry on. Every error sets a sticky flag and records the failing address until a clear pulse.

A one-cycle done pulse marks the end of a run. The run ends when its last beat finishes, or when an error drops the rest of it. The grant input gates whether any new address may be issued.

Top module: `ahb_replay_master`

## Requirements
- R1: A start pulse with a non-zero length N while idle produces N accepted transfers at base, base+4, and so on. The first carries transfer type NONSEQ (2'b10) and each following one SEQ (2'b11); no transfer is IDLE (2'b00) then. A start pulse while a run is active, or with length 0, is ignored.
- R2: While ready is low and the response is OKAY (2'b00), the transfer type and address outputs hold their values.
- R3: When ready is low with response RETRY (2'b10) in a data phase, the next cycle shows IDLE. The same address is then re-issued as NONSEQ, and this repeats until it completes OKAY.
- R4: After the first cycle of a SPLIT (2'b11) response the next cycle shows IDLE. No transfer is issued until grant has been sampled low and then high again. The split address is then re-issued as NONSEQ.
- R5: No transfer is issued while grant is low. The first transfer after any IDLE cycle is NONSEQ.
- R6: With the abandon policy set, the first cycle of an ERROR (2'b01) response makes the next cycle IDLE. No further beat of that run is issued.
- R7: With the abandon policy clear, an ERROR beat is not repeated and the remaining beats are issued and complete unchanged.
- R8: done is high for exactly one cycle per run. It rises after the edge that ends the last beat (OKAY or ERROR), or after the edge that ends an ERROR beat under the abandon policy.
- R9: err_flag goes high after an ERROR first cycle and stays high until err_clear. err_addr keeps the address of the first error since the last clear.
- R10: When err_clear coincides with an ERROR first cycle, err_flag stays high and err_addr takes the new failing address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| start | input | 1 | Launch pulse for a run |
| burst_len | input | LW | Number of beats in the run |
| base_addr | input | AW | Address of the first beat |
| abandon_on_err | input | 1 | 1: drop the rest of the run after an ERROR; 0: continue |
| grant | input | 1 | Bus ownership from the arbiter |
| hready | input | 1 | Slave ready for the current data phase |
| hresp | input | 2 | Slave response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| err_clear | input | 1 | Clears the sticky error flag |
| htrans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ, 11 SEQ |
| haddr | output | AW | Transfer address |
| done | output | 1 | One-cycle end-of-run pulse |
| err_flag | output | 1 | Sticky error indicator |
| err_addr | output | AW | Address of the first error since the last clear |

## Verification
The clear pulse for the error log and a fresh ERROR first cycle can fall on the same edge; set must win, and the address must be replaced rather than kept. The bench's slave model raises err_clear itself in exactly the cycle it drives ready low with ERROR. It then judges err_flag and err_addr once the run has ended. Cancel and done are the other pair that meet: under the abandon policy, the cancel edge and the done edge are consecutive. The bench checks IDLE on the cancel cycle, and that exactly one done follows with no further transfer.

// File: rtl/ahbrm_pkg.sv
package ahbrm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_e;
endpackage

// File: rtl/ahbrm_resp_class.sv
module ahbrm_resp_class
  import ahbrm_pkg::*;
(
  input  logic       d_valid,
  input  logic       hready,
  input  logic [1:0] hresp,
  output logic       first_replay,
  output logic       first_split,
  output logic       first_err,
  output logic       end_ok,
  output logic       end_err
);
  // Splits the slave's answer into the first (ready low) and the
  // final (ready high) cycle of a data phase.
  always_comb begin
    first_replay = 1'b0;
    first_split  = 1'b0;
    first_err    = 1'b0;
    end_ok       = 1'b0;
    end_err      = 1'b0;
    if (d_valid) begin
      if (!hready) begin
        first_replay = (hresp == RS_RETRY) || (hresp == RS_SPLIT);
        first_split  = (hresp == RS_SPLIT);
        first_err    = (hresp == RS_ERROR);
      end else begin
        end_ok  = (hresp == RS_OKAY);
        end_err = (hresp == RS_ERROR);
      end
    end
  end
endmodule

// File: rtl/ahbrm_split_park.sv
module ahbrm_split_park (
  input  logic clk,
  input  logic rst_n,
  input  logic park_set,
  input  logic issued,
  input  logic grant,
  output logic go_ok
);
  logic parked_q, parked_n;
  logic low_q, low_n;

  always_comb begin
    parked_n = parked_q;
    low_n    = low_q;
    if (park_set) begin
      parked_n = 1'b1;
      low_n    = 1'b0;
    end else if (issued) begin
      parked_n = 1'b0;
      low_n    = 1'b0;
    end else if (parked_q && !grant) begin
      low_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked_q <= 1'b0;
      low_q    <= 1'b0;
    end else begin
      parked_q <= parked_n;
      low_q    <= low_n;
    end
  end

  // Parked masters wait for the bus to be taken away and given back.
  assign go_ok = !parked_q || (low_q && grant);
endmodule

// File: rtl/ahbrm_err_log.sv
module ahbrm_err_log #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          clear,
  output logic          flag,
  output logic [AW-1:0] addr
);
  logic          flag_q, flag_n;
  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    flag_n = flag_q;
    addr_n = addr_q;
    if (set) begin
      flag_n = 1'b1;
      if (!flag_q || clear) addr_n = set_addr;
    end else if (clear) begin
      flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_n;
      addr_q <= addr_n;
    end
  end

  assign flag = flag_q;
  assign addr = addr_q;
endmodule

// File: rtl/ahb_replay_master.sv
module ahb_replay_master
  import ahbrm_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] burst_len,
  input  logic [AW-1:0] base_addr,
  input  logic          abandon_on_err,
  input  logic          grant,
  input  logic          hready,
  input  logic [1:0]    hresp,
  input  logic          err_clear,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          done,
  output logic          err_flag,
  output logic [AW-1:0] err_addr
);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // run state
  logic          running_q, running_n;
  logic [LW-1:0] len_q, len_n;
  logic [AW-1:0] base_q, base_n;
  logic          abandon_q, abandon_n;
  logic [LW-1:0] nb_q, nb_n;
  // address phase
  logic [1:0]    htrans_q, htrans_n;
  logic [AW-1:0] haddr_q, haddr_n;
  logic [LW-1:0] a_beat_q, a_beat_n;
  // data phase
  logic          d_valid_q, d_valid_n;
  logic [LW-1:0] d_beat_q, d_beat_n;
  logic [AW-1:0] d_addr_q, d_addr_n;
  logic          done_q, done_n;

  logic first_replay, first_split, first_err, end_ok, end_err;
  logic cancel, can_issue, issue_fire, go_ok, last_beat;

  ahbrm_resp_class u_cls (
    .d_valid     (d_valid_q),
    .hready      (hready),
    .hresp       (hresp),
    .first_replay(first_replay),
    .first_split (first_split),
    .first_err   (first_err),
    .end_ok      (end_ok),
    .end_err     (end_err)
  );

  ahbrm_split_park u_park (
    .clk     (clk),
    .rst_n   (srst_n),
    .park_set(first_split),
    .issued  (issue_fire),
    .grant   (grant),
    .go_ok   (go_ok)
  );

  ahbrm_err_log #(.AW(AW)) u_elog (
    .clk     (clk),
    .rst_n   (srst_n),
    .set     (first_err),
    .set_addr(d_addr_q),
    .clear   (err_clear),
    .flag    (err_flag),
    .addr    (err_addr)
  );

  assign cancel     = first_replay || (first_err && abandon_q);
  assign can_issue  = running_q && (nb_q < len_q) && grant && go_ok;
  assign issue_fire = hready && !cancel && can_issue;
  assign last_beat  = (d_beat_q == len_q - ONE);

  always_comb begin
    running_n = running_q;
    len_n     = len_q;
    base_n    = base_q;
    abandon_n = abandon_q;
    nb_n      = nb_q;
    htrans_n  = htrans_q;
    haddr_n   = haddr_q;
    a_beat_n  = a_beat_q;
    d_valid_n = d_valid_q;
    d_beat_n  = d_beat_q;
    d_addr_n  = d_addr_q;
    done_n    = 1'b0;

    if (cancel) begin
      // withdraw the pipelined address during the two-cycle response
      htrans_n = TR_IDLE;
      if (first_replay) nb_n = d_beat_q;
      else              running_n = 1'b0;
    end else if (hready) begin
      d_valid_n = (htrans_q != TR_IDLE);
      d_beat_n  = a_beat_q;
      d_addr_n  = haddr_q;
      if (can_issue) begin
        htrans_n = (htrans_q != TR_IDLE) ? TR_SEQ : TR_NONSEQ;
        haddr_n  = base_q + AW'({nb_q, 2'b00});
        a_beat_n = nb_q;
        nb_n     = nb_q + ONE;
      end else begin
        htrans_n = TR_IDLE;
      end
      if ((end_ok && last_beat) || (end_err && (abandon_q || last_beat))) begin
        done_n    = 1'b1;
        running_n = 1'b0;
      end
    end

    if (start && !running_q && (burst_len != '0)) begin
      running_n = 1'b1;
      len_n     = burst_len;
      base_n    = base_addr;
      abandon_n = abandon_on_err;
      nb_n      = '0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      running_q <= 1'b0;
      len_q     <= '0;
      base_q    <= '0;
      abandon_q <= 1'b0;
      nb_q      <= '0;
      htrans_q  <= TR_IDLE;
      haddr_q   <= '0;
      a_beat_q  <= '0;
      d_valid_q <= 1'b0;
      d_beat_q  <= '0;
      d_addr_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      running_q <= running_n;
      len_q     <= len_n;
      base_q    <= base_n;
      abandon_q <= abandon_n;
      nb_q      <= nb_n;
      htrans_q  <= htrans_n;
      haddr_q   <= haddr_n;
      a_beat_q  <= a_beat_n;
      d_valid_q <= d_valid_n;
      d_beat_q  <= d_beat_n;
      d_addr_q  <= d_addr_n;
      done_q    <= done_n;
    end
  end

  assign htrans = htrans_q;
  assign haddr  = haddr_q;
  assign done   = done_q;
endmodule

// File: rtl/ahbrm_checker.sv
module ahbrm_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic [1:0]    hresp,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic          done,
  input logic          err_flag,
  input logic          err_clear,
  input logic          d_valid
);
  a_r3_idle_after_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !hready && hresp[1]) |=> (htrans == 2'b00));

  a_r2_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && hresp == 2'b00) |=> ($stable(htrans) && $stable(haddr)));

  a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans != 2'b00) |=> (htrans != 2'b11 || haddr == $past(haddr) + AW'(4)));

  a_r1_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    htrans != 2'b01);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ahb_replay_master ahbrm_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hready   (hready),
  .hresp    (hresp),
  .htrans   (htrans),
  .haddr    (haddr),
  .done     (done),
  .err_flag (err_flag),
  .err_clear(err_clear),
  .d_valid  (d_valid_q)
);

// File: tb/sim_ahb_replay_master.sv
module sim_ahb_replay_master;
  localparam int AW = 32;
  localparam int LW = 5;
  localparam int K_OK = 0, K_WAIT = 1, K_RETRY = 2, K_SPLIT = 3, K_ERR = 4;

  logic          clk, rst_n, start, abandon_on_err, grant, hready, err_clear;
  logic [LW-1:0] burst_len;
  logic [AW-1:0] base_addr, haddr, err_addr;
  logic [1:0]    hresp, htrans;
  logic          done, err_flag;

  int n_run = 0, n_fail = 0, done_cnt = 0, acc_cnt = 0;
  logic [AW-1:0] q_addr[$];
  logic [1:0]    q_trans[$];
  int            plan[$];
  bit            collide_arm = 0, clr_req = 0;
  string         cur_req = "R1";

  ahb_replay_master #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
    .base_addr(base_addr), .abandon_on_err(abandon_on_err), .grant(grant),
    .hready(hready), .hresp(hresp), .err_clear(err_clear),
    .htrans(htrans), .haddr(haddr), .done(done),
    .err_flag(err_flag), .err_addr(err_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic expect_xfer(input logic [AW-1:0] a, input logic [1:0] t);
    q_addr.push_back(a);
    q_trans.push_back(t);
  endtask

  task automatic launch(input logic [AW-1:0] b, input int n, input bit ab);
    base_addr = b; burst_len = LW'(n); abandon_on_err = ab; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    int guard = 0;
    while (done_cnt < target && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == target, req, "done pulses", done_cnt, target);
    chk(q_addr.size() == 0, cur_req, "expected transfers left", q_addr.size(), 0);
  endtask

  // Slave model and monitor: drives ready/response, scores accepted addresses.
  initial begin : slave
    bit dp_on = 0, acc_next = 0, p_valid = 0;
    int dp_cnt = 0, dp_kind = K_OK, kind_next = K_OK;
    logic [1:0] p_htrans = 2'b00;
    logic [AW-1:0] p_haddr = '0;
    hready = 1'b1; hresp = 2'b00; err_clear = 1'b0;
    forever begin
      @(negedge clk);
      err_clear = 1'b0;
      if (clr_req) begin err_clear = 1'b1; clr_req = 0; end
      if (!rst_n) begin
        hready = 1'b1; hresp = 2'b00; dp_on = 0; acc_next = 0; p_valid = 0;
        continue;
      end
      if (done) done_cnt++;
      if (p_valid && !hready && hresp == 2'b00)
        chk(htrans == p_htrans && haddr == p_haddr, "R2", "hold during wait", haddr, p_haddr);
      if (dp_on) begin
        if (hready) dp_on = 0;
        else dp_cnt++;
      end
      if (acc_next) begin dp_on = 1; dp_cnt = 0; dp_kind = kind_next; acc_next = 0; end
      hready = 1'b1; hresp = 2'b00;
      if (dp_on) begin
        case (dp_kind)
          K_WAIT:  hready = (dp_cnt >= 2);
          K_RETRY: begin hresp = 2'b10; hready = (dp_cnt >= 1); end
          K_SPLIT: begin hresp = 2'b11; hready = (dp_cnt >= 1); end
          K_ERR:   begin hresp = 2'b01; hready = (dp_cnt >= 1); end
          default: ;
        endcase
        if (dp_cnt == 1) begin
          if (dp_kind == K_RETRY) chk(htrans == 2'b00, "R3", "IDLE after retry", htrans, 0);
          if (dp_kind == K_SPLIT) chk(htrans == 2'b00, "R4", "IDLE after split", htrans, 0);
          if (dp_kind == K_ERR && abandon_on_err)
            chk(htrans == 2'b00, "R6", "IDLE after error", htrans, 0);
        end
        if (dp_kind == K_ERR && dp_cnt == 0 && collide_arm) begin
          err_clear = 1'b1; collide_arm = 0;  // R10 collision
        end
      end
      if (hready && htrans != 2'b00) begin
        acc_cnt++;
        if (q_addr.size() == 0) chk(1'b0, cur_req, "unexpected transfer", haddr, 0);
        else begin
          logic [AW-1:0] ea;
          logic [1:0] et;
          ea = q_addr.pop_front();
          et = q_trans.pop_front();
          chk(haddr == ea, cur_req, "address", haddr, ea);
          chk(htrans == et, cur_req, "transfer type", htrans, et);
        end
        acc_next = 1;
        kind_next = (plan.size() != 0) ? plan.pop_front() : K_OK;
      end
      p_htrans = htrans; p_haddr = haddr; p_valid = 1;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin : main
    int a0;
    rst_n = 1'b0; start = 1'b0; burst_len = '0; base_addr = '0;
    abandon_on_err = 1'b0; grant = 1'b1;
    repeat (3) @(negedge clk);
    chk(htrans == 2'b00, "R1", "reset htrans", htrans, 0);
    chk(done == 1'b0, "R8", "reset done", done, 0);
    chk(err_flag == 1'b0, "R9", "reset err_flag", err_flag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: plain run, also len 0 start ignored
    cur_req = "R1";
    launch(32'h40, 0, 0);
    repeat (4) @(negedge clk);
    chk(acc_cnt == 0, "R1", "zero length ignored", acc_cnt, 0);
    expect_xfer(32'h100, 2'b10); expect_xfer(32'h104, 2'b11);
    expect_xfer(32'h108, 2'b11); expect_xfer(32'h10C, 2'b11);
    plan = '{K_OK, K_OK, K_OK, K_OK};
    launch(32'h100, 4, 0);
    wait_done(1, "R8");
    chk(err_flag == 1'b0, "R9", "no error flag", err_flag, 0);

    // R2: wait states leave the sequence intact
    cur_req = "R2";
    expect_xfer(32'h200, 2'b10); expect_xfer(32'h204, 2'b11); expect_xfer(32'h208, 2'b11);
    plan = '{K_WAIT, K_OK, K_WAIT};
    launch(32'h200, 3, 0);
    wait_done(2, "R8");

    // R3: retry of beat 1, pipelined 308 withdrawn
    cur_req = "R3";
    expect_xfer(32'h300, 2'b10); expect_xfer(32'h304, 2'b11);
    expect_xfer(32'h304, 2'b10); expect_xfer(32'h308, 2'b11);
    plan = '{K_OK, K_RETRY, K_OK, K_OK};
    launch(32'h300, 3, 0);
    wait_done(3, "R8");

    // R3: repeated retry
    expect_xfer(32'h400, 2'b10); expect_xfer(32'h400, 2'b10); expect_xfer(32'h400, 2'b10);
    plan = '{K_RETRY, K_RETRY, K_OK};
    launch(32'h400, 1, 0);
    wait_done(4, "R8");

    // R4: split parks until grant low then high
    cur_req = "R4";
    expect_xfer(32'h500, 2'b10); expect_xfer(32'h500, 2'b10); expect_xfer(32'h504, 2'b11);
    plan = '{K_SPLIT, K_OK, K_OK};
    a0 = acc_cnt;
    launch(32'h500, 2, 0);
    repeat (12) @(negedge clk);
    chk(acc_cnt - a0 == 1, "R4", "parked while grant held", acc_cnt - a0, 1);
    grant = 1'b0;
    repeat (2) @(negedge clk);
    grant = 1'b1;
    wait_done(5, "R8");

    // R5: no issue without grant
    cur_req = "R5";
    grant = 1'b0;
    expect_xfer(32'hA00, 2'b10); expect_xfer(32'hA04, 2'b11); expect_xfer(32'hA08, 2'b11);
    plan = '{K_OK, K_OK, K_OK};
    a0 = acc_cnt;
    launch(32'hA00, 3, 0);
    repeat (6) @(negedge clk);
    chk(acc_cnt == a0, "R5", "no transfer without grant", acc_cnt - a0, 0);
    grant = 1'b1;
    wait_done(6, "R8");

    // R6: abandon on error
    cur_req = "R6";
    expect_xfer(32'h600, 2'b10); expect_xfer(32'h604, 2'b11);
    plan = '{K_OK, K_ERR};
    a0 = acc_cnt;
    launch(32'h600, 4, 1);
    wait_done(7, "R8");
    repeat (4) @(negedge clk);
    chk(acc_cnt - a0 == 2, "R6", "beats after abandon", acc_cnt - a0, 2);
    chk(err_flag == 1'b1, "R9", "flag after error", err_flag, 1);
    chk(err_addr == 32'h604, "R9", "failing address", err_addr, 32'h604);

    // R9: clear
    clr_req = 1;
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b0, "R9", "flag cleared", err_flag, 0);

    // R7: continue after error
    cur_req = "R7";
    expect_xfer(32'h700, 2'b10); expect_xfer(32'h704, 2'b11); expect_xfer(32'h708, 2'b11);
    plan = '{K_OK, K_ERR, K_OK};
    a0 = acc_cnt;
    launch(32'h700, 3, 0);
    wait_done(8, "R8");
    chk(acc_cnt - a0 == 3, "R7", "beats after error", acc_cnt - a0, 3);
    chk(err_addr == 32'h704, "R9", "failing address", err_addr, 32'h704);

    // R9: first error kept; R8: error on last beat ends run
    cur_req = "R9";
    expect_xfer(32'h800, 2'b10);
    plan = '{K_ERR};
    launch(32'h800, 1, 0);
    wait_done(9, "R8");
    chk(err_addr == 32'h704, "R9", "first address kept", err_addr, 32'h704);

    // R10: clear collides with new error
    cur_req = "R10";
    collide_arm = 1;
    expect_xfer(32'h900, 2'b10);
    plan = '{K_ERR};
    launch(32'h900, 1, 0);
    wait_done(10, "R8");
    chk(collide_arm == 0, "R10", "collision provoked", collide_arm, 0);
    chk(err_flag == 1'b1, "R10", "flag survives clear", err_flag, 1);
    chk(err_addr == 32'h900, "R10", "address replaced", err_addr, 32'h900);

    clr_req = 1;
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b0, "R9", "final clear", err_flag, 0);
    finish_up();
  end
endmodule